// File: doc/BRIEF.md
# Variable-Period Stallable Microcycle Clock

This block turns a free-running master clock into a one-cycle microcycle strobe for a microprogrammed processor. The microword that is currently executing picks how many master cycles its microcycle lasts. Three lengths are available, so the microcode pays for a long cycle only on the steps that need one. The strobe marks the end of the current microcycle. Microcode advances to the next microword on that strobe.

The block also keeps the processor in step with an external bus that runs asynchronously to it. A configuration input is captured only during reset and selects one of two behaviours. In the freeze behaviour, a microword that starts a bus transfer does not end until the bus reports completion. In the overlap behaviour, a microword that starts a read ends on time, and later microwords keep running while the read is in flight. Only a microword that marks itself as needing the read data stalls, and only while the data is still missing. Write transfers always freeze. Only one transfer may be outstanding at a time. The completion input passes through a two-flop synchronizer and a rising-edge detector before it can release a stall.

Top module: `ucycle_clkgen`

## Requirements
- R1: The period select field sets the microcycle length in master cycles when nothing stalls: 0 gives 4, 1 gives 6, 2 gives 8, and 3 (reserved) gives 8. The field is captured in the first cycle after each strobe.
- R2: The strobe is low while reset is asserted. It is always a single master cycle wide. The first strobe after reset is released comes 4 cycles later, with select 0.
- R3: In freeze mode, a microword with the start flag set launches the transfer at its last cycle and holds the strobe. Counting from the strobe that began the microword as cycle 0, suppose completion rises in cycle d, where d is at least the period minus 1. The next strobe then comes in cycle d+3.
- R4: In overlap mode, a microword that starts a read (start=1, read=1) ends after its normal period. Later microwords that do not flag need-data also run at their normal period while the read is pending.
- R5: In overlap mode, a microword with need-data set that runs while a read is pending ends in cycle max(P, d+3), where P is its period and d is the cycle in which completion rises.
- R6: A need-data microword with no transfer pending inserts no stall cycles, in either mode.
- R7: In overlap mode, a write (start=1, read=0) freezes the processor exactly as R3 describes.
- R8: A start request made while a transfer is still pending waits for the earlier completion. The microword then ends in cycle max(P, d+3) for an overlap read.
- R9: The mode input is captured only during reset. Changing it afterwards has no effect until the next reset.
- R10: Reset clears any pending transfer. A need-data microword right after reset does not stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running master clock |
| rst_i | input | 1 | Synchronous active-high reset |
| ovl_mode_i | input | 1 | Captured during reset: 1 selects overlap, 0 selects freeze |
| period_sel_i | input | 2 | Period select field of the current microword |
| xfer_start_i | input | 1 | Current microword starts a bus transfer |
| xfer_read_i | input | 1 | The transfer being started is a read |
| need_data_i | input | 1 | Current microword waits for read data |
| xfer_done_i | input | 1 | Asynchronous bus completion level |
| ucyc_stb_o | output | 1 | One-cycle end-of-microcycle strobe |

## Verification
Plain microwords with random period selects, including the reserved code, separate the length decoding from any stall path. Freeze-mode transfers with random completion delays fix the exact latency through the synchronizer. Overlap sequences place completion both before and after the need-data microword's last cycle, including the case where the two coincide. This tells a needless stall apart from a missed one. Back-to-back starts, writes in overlap mode, a mode-pin change outside reset, and a reset during a pending read each exercise one rule that the plain read flow leaves untouched.

// File: rtl/ucycle_pkg.sv
package ucycle_pkg;
  localparam int unsigned SEL_W = 2;

  // Period in master cycles for a select code; codes above 2 reuse the longest.
  function automatic int unsigned period_of(input logic [SEL_W-1:0] sel,
                                            input int unsigned p0,
                                            input int unsigned p1,
                                            input int unsigned p2);
    case (sel)
      2'd0:    return p0;
      2'd1:    return p1;
      default: return p2;
    endcase
  endfunction
endpackage

// File: rtl/ucycle_done_sync.sv
module ucycle_done_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk_i) begin
          if (rst_i) chain_q[i] <= 1'b0;
          else       chain_q[i] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk_i) begin
          if (rst_i) chain_q[i] <= 1'b0;
          else       chain_q[i] <= chain_q[i-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk_i) begin
    if (rst_i) prev_q <= 1'b0;
    else       prev_q <= chain_q[STAGES-1];
  end

  assign rise_o = chain_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/ucycle_period_timer.sv
module ucycle_period_timer
  import ucycle_pkg::*;
#(
  parameter int CNT_W = 4,
  parameter int P0    = 4,
  parameter int P1    = 6,
  parameter int P2    = 8
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             fire_i,
  output logic             at_end_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last_q;
  logic [CNT_W-1:0] last_d;

  assign last_d   = CNT_W'(period_of(sel_i, P0, P1, P2) - 1);
  assign at_end_o = (cnt_q == last_q) && (cnt_q != '0);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cnt_q  <= '0;
      last_q <= CNT_W'(P0 - 1);
    end else begin
      if (cnt_q == '0) last_q <= last_d;
      if (fire_i)         cnt_q <= '0;
      else if (!at_end_o) cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/ucycle_xfer_track.sv
module ucycle_xfer_track (
  input  logic clk_i,
  input  logic rst_i,
  input  logic mode_i,
  input  logic at_end_i,
  input  logic start_i,
  input  logic read_i,
  input  logic need_i,
  input  logic done_evt_i,
  output logic fire_o,
  output logic launch_o,
  output logic pending_o,
  output logic ovl_o
);
  logic ovl_q, pending_q, launched_q;
  logic pend_eff, lock;

  assign pend_eff = pending_q & ~done_evt_i;
  assign lock     = ~ovl_q | ~read_i;
  assign launch_o = at_end_i & start_i & ~launched_q & ~pend_eff;

  always_comb begin
    if (!at_end_i)        fire_o = 1'b0;
    else if (start_i) begin
      if (launch_o)        fire_o = ~lock;
      else if (launched_q) fire_o = ~pend_eff;
      else                 fire_o = 1'b0;
    end else               fire_o = ~(need_i & pend_eff);
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      ovl_q      <= mode_i;
      pending_q  <= 1'b0;
      launched_q <= 1'b0;
    end else begin
      if (launch_o)        pending_q <= 1'b1;
      else if (done_evt_i) pending_q <= 1'b0;
      if (fire_o)          launched_q <= 1'b0;
      else if (launch_o)   launched_q <= 1'b1;
    end
  end

  assign pending_o = pending_q;
  assign ovl_o     = ovl_q;
endmodule

// File: rtl/ucycle_clkgen.sv
module ucycle_clkgen
  import ucycle_pkg::*;
#(
  parameter int CNT_W       = 4,
  parameter int P0          = 4,
  parameter int P1          = 6,
  parameter int P2          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             ovl_mode_i,
  input  logic [SEL_W-1:0] period_sel_i,
  input  logic             xfer_start_i,
  input  logic             xfer_read_i,
  input  logic             need_data_i,
  input  logic             xfer_done_i,
  output logic             ucyc_stb_o
);
  logic done_evt, at_end, fire, launch, pending_q, ovl_q;

  ucycle_done_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_i(rst_i), .async_i(xfer_done_i), .rise_o(done_evt)
  );

  ucycle_period_timer #(.CNT_W(CNT_W), .P0(P0), .P1(P1), .P2(P2)) u_timer (
    .clk_i(clk_i), .rst_i(rst_i), .sel_i(period_sel_i), .fire_i(fire),
    .at_end_o(at_end)
  );

  ucycle_xfer_track u_track (
    .clk_i(clk_i), .rst_i(rst_i), .mode_i(ovl_mode_i), .at_end_i(at_end),
    .start_i(xfer_start_i), .read_i(xfer_read_i), .need_i(need_data_i),
    .done_evt_i(done_evt), .fire_o(fire), .launch_o(launch),
    .pending_o(pending_q), .ovl_o(ovl_q)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i) ucyc_stb_o <= 1'b0;
    else       ucyc_stb_o <= fire;
  end
endmodule

// File: rtl/ucycle_clkgen_chk.sv
module ucycle_clkgen_chk (
  input logic clk_i,
  input logic rst_i,
  input logic stb_i,
  input logic fire_i,
  input logic launch_i,
  input logic pending_i,
  input logic ovl_i,
  input logic done_evt_i
);
  logic [7:0] since_q;
  logic       seen_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      since_q <= '0;
      seen_q  <= 1'b0;
    end else if (stb_i) begin
      since_q <= '0;
      seen_q  <= 1'b1;
    end else if (since_q != 8'hFF) begin
      since_q <= since_q + 1'b1;
    end
  end

  p_single_pulse_r2: assert property (@(posedge clk_i) disable iff (rst_i)
    stb_i |=> !stb_i);

  p_reset_quiet_r2: assert property (@(posedge clk_i)
    rst_i |=> !stb_i);

  p_min_gap_r1: assert property (@(posedge clk_i) disable iff (rst_i)
    (stb_i && seen_q) |-> (since_q >= 8'd3));

  p_freeze_hold_r3: assert property (@(posedge clk_i) disable iff (rst_i)
    (!ovl_i && pending_i && !done_evt_i) |-> !fire_i);

  p_one_outstanding_r8: assert property (@(posedge clk_i) disable iff (rst_i)
    launch_i |-> (!pending_i || done_evt_i));
endmodule

bind ucycle_clkgen ucycle_clkgen_chk u_chk (
  .clk_i(clk_i), .rst_i(rst_i), .stb_i(ucyc_stb_o), .fire_i(fire),
  .launch_i(launch), .pending_i(pending_q), .ovl_i(ovl_q),
  .done_evt_i(done_evt)
);

// File: tb/tb_ucycle_clkgen.sv
`timescale 1ns/1ps
module tb_ucycle_clkgen;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       mode = 1'b0;
  logic [1:0] sel = 2'd0;
  logic       start = 1'b0, rd = 1'b0, need = 1'b0, done = 1'b0;
  logic       stb;
  int checks = 0, errors = 0, done_hold = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  ucycle_clkgen dut (
    .clk_i(clk), .rst_i(rst), .ovl_mode_i(mode), .period_sel_i(sel),
    .xfer_start_i(start), .xfer_read_i(rd), .need_data_i(need),
    .xfer_done_i(done), .ucyc_stb_o(stb)
  );

  function automatic int per(input logic [1:0] s);
    return (s == 2'd0) ? 4 : (s == 2'd1) ? 6 : 8;
  endfunction

  function automatic int exp_len(input logic [1:0] s, input int d);
    if (d < 0) return per(s);
    return (per(s) > d + 3) ? per(s) : d + 3;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick_done(input int cyc, input int d);
    if (done_hold > 0) begin
      done_hold--;
      if (done_hold == 0) done = 1'b0;
    end
    if (cyc == d) begin
      done = 1'b1;
      done_hold = 4;
    end
  endtask

  // Called at the negedge where a strobe is seen (cycle 0 of the microword).
  task automatic run_uword(input logic [1:0] s, input bit st, input bit r,
                           input bit nd, input int d, input int exp, input string tag);
    int cyc = 0;
    bit width_ok = 1;
    sel = s; start = st; rd = r; need = nd;
    tick_done(0, d);
    forever begin
      @(negedge clk);
      cyc++;
      tick_done(cyc, d);
      if (stb) break;
      if (cyc > 300) break;
    end
    chk(cyc == exp, tag, cyc, exp);
  endtask

  task automatic do_reset(input bit m);
    int cyc = 0;
    bit quiet = 1;
    @(negedge clk);
    rst = 1'b1; mode = m; sel = 2'd0; start = 0; rd = 0; need = 0;
    done = 1'b0; done_hold = 0;
    repeat (3) begin
      @(negedge clk);
      if (stb) quiet = 0;
    end
    chk(quiet, "R2 strobe low in reset", stb, 0);
    rst = 1'b0;
    forever begin
      @(negedge clk);
      cyc++;
      if (stb || cyc > 50) break;
    end
    chk(cyc == 4, "R2 first strobe after reset", cyc, 4);
    @(negedge clk);
    chk(!stb, "R2 strobe one cycle wide", stb, 0);
    // Realign: wait for the next strobe so callers start at cycle 0.
    forever begin
      @(negedge clk);
      if (stb) break;
    end
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [1:0] s;
    int d, k;
    void'($urandom(32'd1234));

    // Freeze mode
    do_reset(1'b0);
    for (int i = 0; i < 4; i++)
      run_uword(2'(i), 0, 0, 0, -1, per(2'(i)), "R1 period code");
    for (int i = 0; i < 20; i++) begin
      s = 2'($urandom_range(0, 3));
      run_uword(s, 0, 0, 0, -1, per(s), "R1 random period");
    end
    run_uword(2'd0, 1, 1, 0, 5, 8, "R3 freeze read");
    for (int i = 0; i < 10; i++) begin
      s = 2'($urandom_range(0, 3));
      d = per(s) - 1 + int'($urandom_range(0, 6));
      run_uword(s, 1, $urandom_range(0, 1) == 1, 0, d, d + 3, "R3 random freeze");
      run_uword(2'd0, 0, 0, 0, -1, 4, "R3 after release");
    end
    run_uword(2'd1, 0, 0, 1, -1, 6, "R6 need-data idle freeze mode");
    mode = 1'b1;
    run_uword(2'd0, 0, 0, 0, -1, 4, "R9 spacer");
    run_uword(2'd0, 1, 1, 0, 10, 13, "R9 mode pin ignored outside reset");
    run_uword(2'd0, 0, 0, 0, -1, 4, "R9 spacer");

    // Overlap mode
    do_reset(1'b1);
    run_uword(2'd1, 1, 1, 0, -1, 6, "R4 read launch no stall");
    run_uword(2'd0, 0, 0, 0, -1, 4, "R4 plain during read");
    run_uword(2'd2, 0, 0, 0, -1, 8, "R4 plain during read");
    run_uword(2'd0, 0, 0, 1, 2, 5, "R5 need-data stall");
    run_uword(2'd0, 0, 0, 1, -1, 4, "R6 need-data after done");
    run_uword(2'd0, 1, 1, 0, -1, 4, "R4 read launch");
    run_uword(2'd0, 0, 0, 1, 1, 4, "R5 done meets last cycle");
    run_uword(2'd0, 1, 1, 0, -1, 4, "R4 read launch");
    run_uword(2'd2, 0, 0, 0, 1, 8, "R4 done during plain");
    run_uword(2'd0, 0, 0, 1, -1, 4, "R6 data already there");
    run_uword(2'd0, 1, 1, 0, -1, 4, "R8 first read");
    run_uword(2'd1, 1, 1, 0, 7, 10, "R8 second start waits");
    run_uword(2'd0, 0, 0, 1, 4, 7, "R8 second read completes");
    run_uword(2'd0, 1, 0, 0, 5, 8, "R7 overlap write freezes");
    run_uword(2'd0, 0, 0, 0, -1, 4, "R7 spacer");
    for (int i = 0; i < 12; i++) begin
      s = 2'($urandom_range(0, 3));
      run_uword(s, 1, 1, 0, -1, per(s), "R4 random launch");
      k = int'($urandom_range(0, 2));
      for (int j = 0; j < k; j++) run_uword(2'd0, 0, 0, 0, -1, 4, "R4 random plain");
      s = 2'($urandom_range(0, 3));
      d = int'($urandom_range(0, 12));
      run_uword(s, 0, 0, 1, d, exp_len(s, d), "R5 random wait");
      run_uword(2'd0, 0, 0, 0, -1, 4, "R5 spacer");
    end
    run_uword(2'd0, 1, 1, 0, -1, 4, "R10 read before reset");
    do_reset(1'b1);
    run_uword(2'd0, 0, 0, 1, -1, 4, "R10 pending cleared by reset");

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule